// File: doc/BRIEF.md
# Paged Nonvolatile Memory with Timed Page Commit

This block is a synchronous, cycle-level model of a byte-wide paged nonvolatile memory. The host uses it like a static RAM, with a chip enable, an output enable, a write enable, an address and separate data-in and data-out buses. Bus writes are not stored in the array straight away. Each one is captured into a page latch, so the bus is free as soon as the byte has been taken. A page load gathers anywhere from one byte to a whole page. The load is closed when the host stops writing for a set number of clocks. An internal timer then programs the collected bytes into the array with no further host action.

While that commit runs, the device remains readable but never returns array data. Each read yields a polling byte whose top bit is the inverse of bit 7 of the last byte accepted, and whose other bits are zero. The host reads until it sees its own data, which marks the end of the write. Writes offered during the commit are dropped. The full-size part uses a 15-bit address (ADDR_W = 15, 32768 bytes). The default build uses a smaller array so that it elaborates quickly. The page write time comes in two grades, short and long, and each is given as a clock-cycle count. A single parameter picks which grade is in use.

Top module: `paged_nvm`

## Requirements
- R1: While reset is held, and on the first clock after it is released with no read in progress, dout is 8'h00.
- R2: A write is accepted only on a rising clock edge where chip_en=1, wr_en=1 and out_en=0. A write offered with out_en=1, or with chip_en=0, changes no array byte and starts no page load.
- R3: dout is registered. After a rising edge where chip_en=1 and out_en=1, dout shows the read result. After any other edge, dout is 8'h00.
- R4: A page spans 64 bytes. Address bits [ADDR_W-1:6] select the page and bits [5:0] select the byte within it. The page is taken from the first accepted write of a load. A later write with different page bits still lands at its offset inside that first page.
- R5: A load stays open while each accepted write follows the previous one within LOAD_WINDOW clocks. When LOAD_WINDOW edges pass after the last accepted write with no new write, the commit begins on that edge.
- R6: During a commit, a read returns {~b7, 7'b0000000}, where b7 is bit 7 of the last accepted byte.
- R7: Writes offered during a commit are ignored. They change neither the array nor the polling byte.
- R8: A commit is busy for exactly COMMIT_CYCLES edges. The short grade is used when SLOW_GRADE=0 and the long grade when it is 1. A read taken LOAD_WINDOW+COMMIT_CYCLES+1 edges after the last write returns the new array data.
- R9: Only offsets written during the load are updated. Every other byte of the page keeps its previous value.
- R10: A load of a single byte and a load of all 64 bytes of a page both commit correctly.
- R11: If one offset is written more than once in a load, the last value written is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Device select, active high |
| out_en | input | 1 | Read enable for the data output, active high |
| wr_en | input | 1 | Write strobe, active high |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or polling byte |

## Verification
Read data is due one edge after the edge that takes the read, so each read is checked 1 ns after that edge. The bench counts edges from the last accepted write. It expects old array data up to edge LOAD_WINDOW, polling bytes from edge LOAD_WINDOW+1 through LOAD_WINDOW+COMMIT_CYCLES, and new data at the edge after that, and it checks at each of those boundaries. For ignored writes, the bench waits past the point where a wrongly started load would have made the device busy, then reads the affected addresses and the polling byte through the bus.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } nvm_state_e;

  // Byte returned on a read while the page is being programmed
  function automatic logic [7:0] poll_byte(input logic last_msb);
    return {~last_msb, 7'b000_0000};
  endfunction

endpackage

// File: rtl/nvm_write_timer.sv
module nvm_write_timer
  import nvm_pkg::*;
#(
  parameter int PAGE_BYTES    = 64,
  parameter int LOAD_WINDOW   = 16,
  parameter int COMMIT_CYCLES = 300
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_req,
  output logic                          take_wr,
  output logic                          first_wr,
  output logic                          busy,
  output logic                          commit_step,
  output logic [$clog2(PAGE_BYTES)-1:0] commit_slot,
  output logic                          commit_done
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int WIN_W = $clog2(LOAD_WINDOW + 1);
  localparam int CMT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOAD_WINDOW - 1);
  localparam logic [CMT_W-1:0] CMT_LAST = CMT_W'(COMMIT_CYCLES - 1);
  localparam logic [CMT_W-1:0] CMT_PROG = CMT_W'(PAGE_BYTES);

  nvm_state_e       state;
  logic [WIN_W-1:0] win_cnt;
  logic [CMT_W-1:0] cmt_cnt;

  assign take_wr     = wr_req && (state != ST_COMMIT);
  assign first_wr    = take_wr && (state == ST_IDLE);
  assign busy        = (state == ST_COMMIT);
  assign commit_step = busy && (cmt_cnt < CMT_PROG);
  assign commit_slot = cmt_cnt[OFF_W-1:0];
  assign commit_done = busy && (cmt_cnt == CMT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      win_cnt <= '0;
      cmt_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take_wr) begin
            state   <= ST_LOAD;
            win_cnt <= '0;
          end
        end
        ST_LOAD: begin
          if (take_wr) begin
            win_cnt <= '0;
          end else if (win_cnt == WIN_LAST) begin
            state   <= ST_COMMIT;
            cmt_cnt <= '0;
          end else begin
            win_cnt <= win_cnt + WIN_W'(1);
          end
        end
        ST_COMMIT: begin
          if (cmt_cnt == CMT_LAST) state <= ST_IDLE;
          else                     cmt_cnt <= cmt_cnt + CMT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  window_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> ($past(win_cnt) == WIN_LAST && !$past(wr_req)));

  // R8
  commit_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> ($past(cmt_cnt) == CMT_LAST));

endmodule

// File: rtl/nvm_page_latch.sv
module nvm_page_latch #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take_wr,
  input  logic                          first_wr,
  input  logic                          clear,
  input  logic                          busy,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [7:0]                    din,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_slot,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
  output logic                          slot_valid,
  output logic [7:0]                    slot_data,
  output logic                          last_msb
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_BYTES-1:0] valid_q;
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_W-1:0]     page_q;
  logic                  msb_q;
  logic [OFF_W-1:0]      wr_off;

  assign wr_off = addr[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      page_q  <= '0;
      msb_q   <= 1'b0;
    end else if (clear) begin
      valid_q <= '0;
    end else if (take_wr) begin
      if (first_wr) page_q <= addr[ADDR_W-1:OFF_W];
      valid_q[wr_off] <= 1'b1;
      msb_q           <= din[7];
    end
  end

  always_ff @(posedge clk) begin
    if (take_wr) data_q[wr_off] <= din;
  end

  assign page       = page_q;
  assign slot_valid = valid_q[rd_slot];
  assign slot_data  = data_q[rd_slot];
  assign last_msb   = msb_q;

  // R7
  latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(valid_q) && $stable(page_q) && $stable(msb_q)));

endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_din,
  input  logic              rd_take,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              last_msb,
  output logic [7:0]        dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[mem_addr] <= mem_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout <= 8'h00;
    else if (rd_take) dout <= busy ? poll_byte(last_msb) : mem_q[rd_addr];
    else              dout <= 8'h00;
  end

  // R3
  idle_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> (dout == 8'h00));

  // R6
  poll_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && busy) |=> (dout == poll_byte($past(last_msb))));

  // R9
  write_in_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

endmodule

// File: rtl/paged_nvm.sv
module paged_nvm #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES   = 64,
  parameter int LOAD_WINDOW  = 16,
  parameter int COMMIT_FAST  = 300,
  parameter int COMMIT_SLOW  = 1000,
  parameter bit SLOW_GRADE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout
);
  localparam int OFF_W         = $clog2(PAGE_BYTES);
  localparam int PAGE_W        = ADDR_W - OFF_W;
  localparam int COMMIT_CYCLES = SLOW_GRADE ? COMMIT_SLOW : COMMIT_FAST;

  logic              bus_wr, bus_rd;
  logic              take_wr, first_wr, busy, commit_step, commit_done;
  logic [OFF_W-1:0]  commit_slot;
  logic [PAGE_W-1:0] page;
  logic              slot_valid, last_msb;
  logic [7:0]        slot_data;
  logic              mem_we;

  assign bus_wr = chip_en && wr_en && !out_en;
  assign bus_rd = chip_en && out_en;
  assign mem_we = commit_step && slot_valid;

  nvm_write_timer #(
    .PAGE_BYTES   (PAGE_BYTES),
    .LOAD_WINDOW  (LOAD_WINDOW),
    .COMMIT_CYCLES(COMMIT_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (bus_wr),
    .take_wr    (take_wr),
    .first_wr   (first_wr),
    .busy       (busy),
    .commit_step(commit_step),
    .commit_slot(commit_slot),
    .commit_done(commit_done)
  );

  nvm_page_latch #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_wr   (take_wr),
    .first_wr  (first_wr),
    .clear     (commit_done),
    .busy      (busy),
    .addr      (addr),
    .din       (din),
    .rd_slot   (commit_slot),
    .page      (page),
    .slot_valid(slot_valid),
    .slot_data (slot_data),
    .last_msb  (last_msb)
  );

  nvm_array #(
    .ADDR_W(ADDR_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_we  (mem_we),
    .mem_addr({page, commit_slot}),
    .mem_din (slot_data),
    .rd_take (bus_rd),
    .rd_addr (addr),
    .busy    (busy),
    .last_msb(last_msb),
    .dout    (dout)
  );

  // R2
  write_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_wr |-> (chip_en && wr_en && !out_en && !busy));

endmodule

// File: tb/paged_nvm_bench.sv
module paged_nvm_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 11;
  localparam int LW = 8;
  localparam int CF = 80;
  localparam int CS = 200;
  localparam int CC = CF;
  localparam int NV = 6;

  // {write address, write data, array address it must land at}
  localparam logic [29:0] VEC [NV] = '{
    {11'h0C5, 8'hA1, 11'h0C5},
    {11'h0C9, 8'h12, 11'h0C9},
    {11'h0C5, 8'h77, 11'h0C5},
    {11'h14A, 8'h5E, 11'h0CA},
    {11'h0FF, 8'h80, 11'h0FF},
    {11'h0C0, 8'h09, 11'h0C0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en = 1'b0, out_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;

  int         checks = 0;
  int         fails = 0;
  logic [7:0] model [1 << AW];
  logic [AW-7:0] bpage;
  logic [7:0] last_d, rd, old_v;

  always #2.5 clk = ~clk;

  paged_nvm #(
    .ADDR_W(AW), .PAGE_BYTES(64), .LOAD_WINDOW(LW),
    .COMMIT_FAST(CF), .COMMIT_SLOW(CS), .SLOW_GRADE(1'b0)
  ) u_paged_nvm (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
    .wr_en(wr_en), .addr(addr), .din(din), .dout(dout)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic bus_idle;
    chip_en = 1'b0; out_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_byte(input logic [AW-1:0] a, input logic [7:0] d, input bit first);
    if (first) bpage = a[AW-1:6];
    chip_en = 1'b1; wr_en = 1'b1; out_en = 1'b0; addr = a; din = d;
    tick();
    bus_idle();
    model[{bpage, a[5:0]}] = d;
    last_d = d;
  endtask

  task automatic read_byte(input logic [AW-1:0] a, output logic [7:0] d);
    chip_en = 1'b1; out_en = 1'b1; wr_en = 1'b0; addr = a;
    tick();
    d = dout;
    bus_idle();
  endtask

  task automatic settle;
    repeat (LW + CC + 2) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) tick();
    check("R1 dout in reset", dout, 8'h00);
    rst_n = 1'b1;
    tick();
    check("R1 dout after reset", dout, 8'h00);

    // R3 no read without both enables
    chip_en = 1'b1; out_en = 1'b0;
    tick();
    check("R3 chip_en only", dout, 8'h00);
    bus_idle(); out_en = 1'b1;
    tick();
    check("R3 out_en only", dout, 8'h00);
    bus_idle();

    // R10 full page load into page 3
    for (int i = 0; i < 64; i++)
      load_byte(AW'(11'h0C0 + i), 8'(i * 7 + 3), i == 0);
    settle();
    for (int i = 0; i < 64; i++) begin
      read_byte(AW'(11'h0C0 + i), rd);
      check("R10 full page", rd, model[11'h0C0 + i]);
    end
    tick();
    check("R3 idle after read", dout, 8'h00);

    // Vector table: R4 R5 R9 R11, with commit timing R5 R6 R8
    old_v = model[11'h0C9];
    for (int v = 0; v < NV; v++) begin
      load_byte(VEC[v][29:19], VEC[v][18:11], v == 0);
      if (v == 2) repeat (LW - 1) tick();   // R5 gap just inside window
    end
    chip_en = 1'b1; out_en = 1'b1; addr = 11'h0C9;
    for (int k = 1; k <= LW + CC + 1; k++) begin
      tick();
      if (k == LW)          check("R5 old data before commit", dout, old_v);
      if (k == LW + 1)      check("R6 poll at commit start", dout, {~last_d[7], 7'b0});
      if (k == LW + CC)     check("R8 poll at commit end", dout, {~last_d[7], 7'b0});
      if (k == LW + CC + 1) check("R8 new data after commit", dout, model[11'h0C9]);
    end
    bus_idle();
    for (int v = 0; v < NV; v++) begin
      read_byte(VEC[v][10:0], rd);
      check("R4 R11 vector readback", rd, model[VEC[v][10:0]]);
    end
    read_byte(11'h14A & 11'h03F | 11'h140, rd);
    read_byte(11'h0CB, rd);
    check("R9 unwritten byte kept", rd, model[11'h0CB]);
    read_byte(11'h0C1, rd);
    check("R9 unwritten byte kept low", rd, model[11'h0C1]);

    // R7 writes during commit ignored; R10 single byte
    load_byte(11'h0C1, 8'hF0, 1'b1);
    repeat (LW + 2) tick();
    chip_en = 1'b1; wr_en = 1'b1; addr = 11'h0C2; din = 8'h55;
    tick();
    addr = 11'h0C1; din = 8'h33;
    tick();
    bus_idle();
    read_byte(11'h0C2, rd);
    check("R7 poll unchanged by ignored write", rd, 8'h00);
    settle();
    read_byte(11'h0C1, rd);
    check("R10 single byte", rd, 8'hF0);
    read_byte(11'h0C2, rd);
    check("R7 ignored write", rd, model[11'h0C2]);
    repeat (LW + 4) tick();
    read_byte(11'h0C2, rd);
    check("R7 no new load", rd, model[11'h0C2]);

    // R2 writes with bad strobes
    chip_en = 1'b1; wr_en = 1'b1; out_en = 1'b1; addr = 11'h0C9; din = 8'hDD;
    tick();
    chip_en = 1'b0; out_en = 1'b0; addr = 11'h0CB; din = 8'hEE;
    tick();
    bus_idle();
    repeat (LW + 3) tick();
    read_byte(11'h0C9, rd);
    check("R2 out_en high write ignored", rd, model[11'h0C9]);
    repeat (CC) tick();
    read_byte(11'h0CB, rd);
    check("R2 chip_en low write ignored", rd, model[11'h0CB]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule